// File: doc/BRIEF.md
# Register-Pair Immediate Add/Subtract Sequencer

This block adds a small unsigned constant to, or subtracts it from, a 16-bit word kept in two neighbouring 8-bit registers of a register file. The even register of the pair holds the low byte and the odd register above it holds the high byte. The block does the word operation with one 8-bit adder spread over two clock cycles. In the first cycle it reads the low byte, writes the new low byte back and keeps the carry or borrow. In the second cycle it reads the high byte, folds the kept carry in and writes the new high byte back. At the end of the second cycle it updates a set of flags that describe the full 16-bit result.

The register file is outside the block. The block drives its read address and uses the returned byte in the same cycle, so the read port must be combinational. It issues one write per cycle while busy. Only the highest register pairs can be chosen, through a small pair index.

Top module: `pair_imm_adder`

## Requirements
- R1: After reset, busy_o, done_o and rf_we_o are 0 and all five flag outputs are 0.
- R2: With sub_i = 0, an accepted start writes the pair's new 16-bit value as (old value + imm_i) mod 65536.
- R3: With sub_i = 1, an accepted start writes the pair's new 16-bit value as (old value - imm_i) mod 65536.
- R4: A start in an idle cycle is accepted. busy_o is then high for exactly the next two cycles. The first cycle writes the low byte and the second writes the high byte at the next address up. done_o pulses for one cycle right after the second write.
- R5: For pair index p (0..3), the low byte lives at register 24 + 2p and the high byte at 25 + 2p.
- R6: z_o is 1 exactly when the whole 16-bit result is zero. A zero low byte with a non-zero high byte gives z_o = 0.
- R7: c_o is the carry out of bit 15 for an add and the borrow (imm_i greater than the old value) for a subtract.
- R8: n_o is bit 15 of the result. v_o is the two's-complement overflow of the 16-bit operation with the immediate taken as positive. s_o equals n_o XOR v_o.
- R9: A start raised while busy_o is high has no effect: no extra cycle, no extra write, and the running operation completes unchanged.
- R10: The flag outputs change only in the cycle in which done_o is high and otherwise hold their value.
- R11: imm_i is 6 bits and unsigned, zero-extended to 16 bits, so any value 0 to 63 is applied in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request an operation (taken only when idle) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| imm_i | input | 6 | Unsigned immediate |
| pair_i | input | 2 | Register pair index |
| rf_raddr_o | output | 5 | Register file read address |
| rf_rdata_i | input | 8 | Register file read data, same cycle |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write address |
| rf_wdata_o | output | 8 | Register file write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the flags are updated |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry/borrow flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| s_o | output | 1 | Sign flag (N XOR V) |

## Verification
The hardest cases to reach from the ports are those where the kept low-byte carry decides the high byte. These are a low byte that wraps to zero while the high byte stays non-zero, and a borrow that runs through both bytes. The stimulus preloads pair values such as 0x11C1, 0x00FF, 0x0000 and 0x8000 through the bench's register file before each start, and draws further values whose low byte sits near 0xFF. Requests that arrive while busy and a fresh start in the done cycle are driven on purpose, so the reference model checks that one operation never merges into the next.

// File: rtl/pia_pkg.sv
package pia_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LO   = 2'd1,
      PH_HI   = 2'd2
   } pia_phase_e;

   typedef struct packed {
      logic z;
      logic c;
      logic n;
      logic v;
      logic s;
   } pia_flags_t;

endpackage

// File: rtl/pia_seq.sv
module pia_seq
   import pia_pkg::*;
#(
   parameter int IMM_W  = 6,
   parameter int PSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sub_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [PSEL_W-1:0] pair_i,
   output pia_phase_e        phase_o,
   output logic              sub_o,
   output logic [IMM_W-1:0]  imm_o,
   output logic [PSEL_W-1:0] pair_o,
   output logic              done_o
);

   pia_phase_e phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sub_o   <= 1'b0;
         imm_o   <= '0;
         pair_o  <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= (phase_q == PH_HI);
         case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_LO;
                  sub_o   <= sub_i;
                  imm_o   <= imm_i;
                  pair_o  <= pair_i;
               end
            end
            PH_LO:   phase_q <= PH_HI;
            PH_HI:   phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/pia_addr_map.sv
module pia_addr_map #(
   parameter int REG_COUNT  = 32,
   parameter int PAIR_COUNT = 4,
   parameter int ADDR_W     = 5,
   parameter int PSEL_W     = 2
) (
   input  logic [PSEL_W-1:0] pair_i,
   input  logic              hi_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int FIRST_ROW = (REG_COUNT - 2 * PAIR_COUNT) / 2;

   logic [ADDR_W-2:0] row_tab [PAIR_COUNT];

   for (genvar g = 0; g < PAIR_COUNT; g++) begin : g_row
      assign row_tab[g] = (ADDR_W-1)'(FIRST_ROW + g);
   end

   assign addr_o = {row_tab[pair_i], hi_i};

endmodule

// File: rtl/pia_byte_alu.sv
module pia_byte_alu #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output logic         cout_o
);

   logic [W:0] ext;

   always_comb begin
      if (sub_i)
         ext = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      else
         ext = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
   end

   assign res_o  = ext[W-1:0];
   assign cout_o = ext[W];

endmodule

// File: rtl/pia_flags.sv
module pia_flags
   import pia_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         sub_i,
   input  logic         a_msb_i,
   input  logic         b_msb_i,
   input  logic [W-1:0] res_i,
   input  logic         cout_i,
   input  logic         lo_zero_i,
   output pia_flags_t   flags_o
);

   pia_flags_t nxt;

   always_comb begin
      nxt.z = lo_zero_i & ~(|res_i);
      nxt.c = cout_i;
      nxt.n = res_i[W-1];
      if (sub_i)
         nxt.v = (a_msb_i ^ b_msb_i) & (a_msb_i ^ res_i[W-1]);
      else
         nxt.v = ~(a_msb_i ^ b_msb_i) & (a_msb_i ^ res_i[W-1]);
      nxt.s = nxt.n ^ nxt.v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         flags_o <= '0;
      else if (load_i)
         flags_o <= nxt;
   end

endmodule

// File: rtl/pair_imm_adder.sv
module pair_imm_adder
   import pia_pkg::*;
#(
   parameter int REG_COUNT  = 32,
   parameter int PAIR_COUNT = 4,
   parameter int DATA_W     = 8,
   parameter int IMM_W      = 6,
   localparam int ADDR_W    = $clog2(REG_COUNT),
   localparam int PSEL_W    = $clog2(PAIR_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sub_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [PSEL_W-1:0] pair_i,
   output logic [ADDR_W-1:0] rf_raddr_o,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic              rf_we_o,
   output logic [ADDR_W-1:0] rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              z_o,
   output logic              c_o,
   output logic              n_o,
   output logic              v_o,
   output logic              s_o
);

   if (IMM_W > DATA_W) begin : g_chk_imm
      $error("pair_imm_adder: IMM_W must not exceed DATA_W");
   end
   if ((1 << PSEL_W) != PAIR_COUNT || PAIR_COUNT < 2) begin : g_chk_pairs
      $error("pair_imm_adder: PAIR_COUNT must be a power of two, at least 2");
   end
   if (2 * PAIR_COUNT > REG_COUNT || (REG_COUNT % 2) != 0) begin : g_chk_regs
      $error("pair_imm_adder: REG_COUNT must be even and hold all pairs");
   end

   pia_phase_e        phase;
   logic              sub_q;
   logic [IMM_W-1:0]  imm_q;
   logic [PSEL_W-1:0] pair_q;
   logic              carry_q;
   logic              lo_zero_q;
   logic [DATA_W-1:0] op_b;
   logic              cin;
   logic [DATA_W-1:0] alu_res;
   logic              alu_cout;
   pia_flags_t        flags;

   pia_seq #(.IMM_W(IMM_W), .PSEL_W(PSEL_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .sub_i   (sub_i),
      .imm_i   (imm_i),
      .pair_i  (pair_i),
      .phase_o (phase),
      .sub_o   (sub_q),
      .imm_o   (imm_q),
      .pair_o  (pair_q),
      .done_o  (done_o)
   );

   pia_addr_map #(
      .REG_COUNT  (REG_COUNT),
      .PAIR_COUNT (PAIR_COUNT),
      .ADDR_W     (ADDR_W),
      .PSEL_W     (PSEL_W)
   ) u_map (
      .pair_i (pair_q),
      .hi_i   (phase == PH_HI),
      .addr_o (rf_raddr_o)
   );

   assign op_b = (phase == PH_LO) ? DATA_W'(imm_q) : '0;
   assign cin  = (phase == PH_HI) ? carry_q : 1'b0;

   pia_byte_alu #(.W(DATA_W)) u_alu (
      .a_i    (rf_rdata_i),
      .b_i    (op_b),
      .cin_i  (cin),
      .sub_i  (sub_q),
      .res_o  (alu_res),
      .cout_o (alu_cout)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_q   <= 1'b0;
         lo_zero_q <= 1'b0;
      end else if (phase == PH_LO) begin
         carry_q   <= alu_cout;
         lo_zero_q <= ~(|alu_res);
      end
   end

   pia_flags #(.W(DATA_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (phase == PH_HI),
      .sub_i     (sub_q),
      .a_msb_i   (rf_rdata_i[DATA_W-1]),
      .b_msb_i   (1'b0),
      .res_i     (alu_res),
      .cout_i    (alu_cout),
      .lo_zero_i (lo_zero_q),
      .flags_o   (flags)
   );

   assign busy_o     = (phase != PH_IDLE);
   assign rf_we_o    = busy_o;
   assign rf_waddr_o = rf_raddr_o;
   assign rf_wdata_o = alu_res;

   assign z_o = flags.z;
   assign c_o = flags.c;
   assign n_o = flags.n;
   assign v_o = flags.v;
   assign s_o = flags.s;

endmodule

// File: rtl/pair_imm_adder_chk.sv
module pair_imm_adder_chk #(
   parameter int REG_COUNT  = 32,
   parameter int PAIR_COUNT = 4,
   parameter int ADDR_W     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              rf_we_o,
   input logic [ADDR_W-1:0] rf_waddr_o,
   input logic              z_o,
   input logic              c_o,
   input logic              n_o,
   input logic              v_o,
   input logic              s_o
);

   localparam int BASE = REG_COUNT - 2 * PAIR_COUNT;

   // R4: a busy period lasts at least two cycles
   a_r4_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |=> busy_o);

   // R9: never a third busy cycle in a row
   a_r9_no_third: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |=> !busy_o);

   // R4: done follows the last busy cycle while the unit is idle
   a_r4_done_after: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o) && !busy_o);

   // R4: the second write goes to the address just above the first
   a_r4_hi_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o && $past(rf_we_o) |-> rf_waddr_o == $past(rf_waddr_o) + 1'b1);

   // R5: the first write of an operation is an even register in the pair window
   a_r5_lo_even: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o && !$past(rf_we_o) |-> !rf_waddr_o[0] && rf_waddr_o >= ADDR_W'(BASE));

   // R10: flags hold outside the done cycle
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({z_o, c_o, n_o, v_o, s_o}));

   // R8: sign flag agrees with negative and overflow
   a_r8_sign: assert property (@(posedge clk) disable iff (!rst_n)
      s_o == (n_o ^ v_o));

endmodule

bind pair_imm_adder pair_imm_adder_chk #(
   .REG_COUNT  (REG_COUNT),
   .PAIR_COUNT (PAIR_COUNT),
   .ADDR_W     (ADDR_W)
) u_chk (.*);

// File: tb/pair_imm_adder_tb.sv
`timescale 1ns/1ps
module pair_imm_adder_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       sub_i = 1'b0;
   logic [5:0] imm_i = '0;
   logic [1:0] pair_i = '0;
   logic [4:0] rf_raddr_o;
   logic [7:0] rf_rdata_i;
   logic       rf_we_o;
   logic [4:0] rf_waddr_o;
   logic [7:0] rf_wdata_o;
   logic       busy_o, done_o, z_o, c_o, n_o, v_o, s_o;

   logic       pl_we = 1'b0;
   logic [4:0] pl_addr = '0;
   logic [7:0] pl_data = '0;
   logic [7:0] mem [32];

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // reference model state
   int         mph = 0;
   int         elo = 0;
   logic       esub = 1'b0;
   logic [15:0] er = '0;
   logic [4:0] ef = '0;   // z c n v s
   logic [4:0] pf = '0;

   always #2 clk = ~clk;

   pair_imm_adder u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
      .imm_i(imm_i), .pair_i(pair_i), .rf_raddr_o(rf_raddr_o),
      .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
      .rf_wdata_o(rf_wdata_o), .busy_o(busy_o), .done_o(done_o),
      .z_o(z_o), .c_o(c_o), .n_o(n_o), .v_o(v_o), .s_o(s_o)
   );

   assign rf_rdata_i = mem[rf_raddr_o];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) mem[i] <= 8'h00;
      end else begin
         if (rf_we_o) mem[rf_waddr_o] <= rf_wdata_o;
         if (pl_we) mem[pl_addr] <= pl_data;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic compare();
      bit    eb;
      string ft;
      string dt;
      eb = (mph == 1 || mph == 2);
      ft = (mph == 3) ? "" : " R10 hold";
      dt = esub ? "R3 subtract byte (R11)" : "R2 add byte (R11)";
      chk(busy_o == eb, "R4 busy", busy_o, eb);
      chk(done_o == (mph == 3), "R4 done pulse", done_o, mph == 3);
      chk(rf_we_o == eb, "R9 write enable", rf_we_o, eb);
      if (mph == 1) begin
         chk(rf_waddr_o == 5'(elo), "R5 low address", rf_waddr_o, elo);
         chk(rf_wdata_o == er[7:0], dt, rf_wdata_o, er[7:0]);
      end
      if (mph == 2) begin
         chk(rf_waddr_o == 5'(elo + 1), "R5 high address", rf_waddr_o, elo + 1);
         chk(rf_wdata_o == er[15:8], dt, rf_wdata_o, er[15:8]);
      end
      chk(z_o == ef[4], {"R6 zero flag", ft}, z_o, ef[4]);
      chk(c_o == ef[3], {"R7 carry flag", ft}, c_o, ef[3]);
      chk(n_o == ef[2], {"R8 negative flag", ft}, n_o, ef[2]);
      chk(v_o == ef[1], {"R8 overflow flag", ft}, v_o, ef[1]);
      chk(s_o == ef[0], {"R8 sign flag", ft}, s_o, ef[0]);
   endtask

   task automatic advance(input logic st, input logic sb, input logic [5:0] im,
                          input logic [1:0] pr);
      int v, r, ir;
      logic zz, cc, nn, vv;
      if ((mph == 0 || mph == 3) && st) begin
         elo  = 24 + 2 * int'(pr);
         esub = sb;
         v    = int'({mem[elo + 1], mem[elo]});
         ir   = int'(im);
         if (sb) begin
            r  = (v - ir + 65536) % 65536;
            cc = ir > v;
            vv = (v >= 32768) && (r < 32768);
         end else begin
            r  = (v + ir) % 65536;
            cc = (v + ir) > 65535;
            vv = (v < 32768) && (r >= 32768);
         end
         er = 16'(r);
         zz = (r == 0);
         nn = (r >= 32768);
         pf = {zz, cc, nn, vv, nn ^ vv};
         mph = 1;
      end else if (mph == 1) begin
         mph = 2;
      end else if (mph == 2) begin
         mph = 3;
         ef  = pf;
      end else begin
         mph = 0;
      end
   endtask

   task automatic step(input logic st, input logic sb, input logic [5:0] im,
                       input logic [1:0] pr, input logic plw, input logic [4:0] pla,
                       input logic [7:0] pld);
      @(negedge clk);
      compare();
      start_i = st;
      sub_i   = sb;
      imm_i   = im;
      pair_i  = pr;
      pl_we   = plw;
      pl_addr = pla;
      pl_data = pld;
      advance(st, sb, im, pr);
   endtask

   task automatic run(input int n);
      repeat (n) step(1'b0, 1'b0, 6'd0, 2'd0, 1'b0, 5'd0, 8'd0);
   endtask

   task automatic preload(input logic [1:0] pr, input logic [15:0] val);
      int lo;
      lo = 24 + 2 * int'(pr);
      step(1'b0, 1'b0, 6'd0, 2'd0, 1'b1, 5'(lo), val[7:0]);
      step(1'b0, 1'b0, 6'd0, 2'd0, 1'b1, 5'(lo + 1), val[15:8]);
   endtask

   task automatic dir(input logic sb, input logic [5:0] im, input logic [1:0] pr,
                      input logic [15:0] val);
      preload(pr, val);
      step(1'b1, sb, im, pr, 1'b0, 5'd0, 8'd0);
      run(3);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(busy_o == 1'b0 && done_o == 1'b0 && rf_we_o == 1'b0, "R1 reset controls",
          {busy_o, done_o, rf_we_o}, 0);
      chk({z_o, c_o, n_o, v_o, s_o} == 5'b0, "R1 reset flags",
          {z_o, c_o, n_o, v_o, s_o}, 0);
      run(2);

      // R2 carry across bytes, R7, R6, R8 overflow, R6 low-zero only
      dir(1'b0, 6'd1,  2'd0, 16'h00FF);
      dir(1'b0, 6'd1,  2'd1, 16'hFFFF);
      dir(1'b0, 6'd1,  2'd2, 16'h7FFF);
      dir(1'b0, 6'd63, 2'd3, 16'h11C1);
      // R3 borrow through both bytes, overflow, zero, zero immediate
      dir(1'b1, 6'd1,  2'd0, 16'h0000);
      dir(1'b1, 6'd1,  2'd1, 16'h8000);
      dir(1'b1, 6'd5,  2'd2, 16'h0005);
      dir(1'b1, 6'd0,  2'd3, 16'h1234);
      dir(1'b1, 6'd63, 2'd0, 16'h0100);

      // R9: start requests while busy are ignored
      preload(2'd1, 16'h40FE);
      step(1'b1, 1'b0, 6'd3, 2'd1, 1'b0, 5'd0, 8'd0);
      step(1'b1, 1'b1, 6'd50, 2'd3, 1'b0, 5'd0, 8'd0);
      step(1'b1, 1'b1, 6'd20, 2'd2, 1'b0, 5'd0, 8'd0);
      step(1'b0, 1'b0, 6'd0, 2'd0, 1'b0, 5'd0, 8'd0);
      run(3);

      // R4: back-to-back start in the done cycle, chained on the same pair
      preload(2'd2, 16'hFFC0);
      step(1'b1, 1'b0, 6'd63, 2'd2, 1'b0, 5'd0, 8'd0);
      run(2);
      step(1'b1, 1'b0, 6'd2, 2'd2, 1'b0, 5'd0, 8'd0);
      run(2);
      step(1'b1, 1'b1, 6'd2, 2'd2, 1'b0, 5'd0, 8'd0);
      run(3);

      // R2 R3 R11 random sweep with boundary-heavy values
      for (int k = 0; k < 300; k++) begin
         logic [15:0] val;
         logic [7:0]  hb, lb;
         hb = 8'($urandom_range(0, 255));
         lb = (k % 3 == 0) ? 8'($urandom_range(192, 255)) : 8'($urandom_range(0, 255));
         val = {hb, lb};
         if (k % 7 == 0) val = 16'($urandom_range(0, 63));
         dir(1'($urandom_range(0, 1)), 6'($urandom_range(0, 63)),
             2'($urandom_range(0, 3)), val);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule